// File: doc/BRIEF.md
# Multi-FIFO Prioritized In-Order Issue Selector

This issue-stage block keeps three in-order instruction queues, one for each readiness class decided at dispatch: operands all present, one operand pending on a nearby producer, and one operand pending on a load. Each cycle it inspects the oldest few entries of every queue and decides which may leave. The first class leaves without any check. The other two classes may leave only once the physical register named by their pending tag is marked ready in a register ready-bit vector.

Grants are packed into a small set of issue slots under a fixed class order and a shared per-cycle cap. Any slot left over may go to a single request from the out-of-order queue. Queues drain only from their heads. Each queue also raises a full flag early enough that dispatch can stall before an entry would be lost.

Top module: `multi_fifo_issue`

## Requirements
- R1: After reset every queue is empty: no issue slot is valid, no full flag is set, and an out-of-order request is granted.
- R2: An entry of the ready class (source code 0) issues whenever it lies within the first LOOK entries of its queue and slots remain, with no operand check.
- R3: An entry of the almost-ready class (code 1) or the load-tail class (code 2) issues only if `reg_ready` is set at the index given by its pending tag.
- R4: Within one queue, the issued entries form an unbroken run starting at the head. The run ends at the first entry that is not ready, at LOOK entries, or when slots run out, so a blocked head holds back every younger entry.
- R5: Issue slots are filled in class order: first the ready class, then almost-ready, then load-tail, then the out-of-order grant (code 3). Within a class, entries appear oldest first. `iss_src` gives the code of each valid slot.
- R6: At most TOTAL slots are valid in a cycle. `oq_grant` is set only when `oq_req` is set and the three queues together take fewer than TOTAL slots; the grant then occupies the next free slot.
- R7: A queue's `fifo_full` bit is set exactly when its free entries number fewer than DISP_W.
- R8: An enqueue into a queue that already holds DEPTH entries is dropped and leaves its contents unchanged.
- R9: An enqueue and an issue from the same queue in the same cycle are both performed, and the queue keeps program order across them.
- R10: Valid slots are contiguous from slot 0. `iss_valid` always has the form 2^k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 3 | Enqueue strobe per class (bit 0 ready, 1 almost-ready, 2 load-tail) |
| enq_data | input | 3*PW | Payload per class, class c in bits [c*PW +: PW] |
| enq_tag | input | 3*TW | Pending-operand tag per class, class c in bits [c*TW +: TW] |
| reg_ready | input | NREG | Ready bit per physical register |
| oq_req | input | 1 | Out-of-order queue has an instruction to issue |
| oq_data | input | PW | Payload of that instruction |
| oq_grant | output | 1 | Out-of-order instruction granted a slot this cycle |
| iss_valid | output | TOTAL | Valid bit per issue slot |
| iss_data | output | TOTAL*PW | Payload per slot, slot s in bits [s*PW +: PW] |
| iss_src | output | 2*TOTAL | Source code per slot, slot s in bits [2s +: 2] |
| fifo_full | output | 3 | Per-class full flag used to stall dispatch |

## Verification
The bench builds the block with DEPTH=8, DISP_W=2, TW=4 (16 registers) and PW=8, and keeps LOOK=3 and TOTAL=4. A shallow depth lets random traffic fill a queue within a few cycles, so both the early full threshold and the dropped enqueue at capacity come up often. A 16-entry ready vector makes tag reuse common, so runs that are blocked and then released occur in many arrangements. With TOTAL one above LOOK, the shared cap spills grants into the second and third classes and still leaves cycles in which the out-of-order request wins or loses its slot.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
    localparam int NCLS = 3;
    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_RDY  = 2'd0,
        SRC_NEAR = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_OOO  = 2'd3
    } slot_src_e;

    function automatic slot_src_e cls_code(input int c);
        case (c)
            0:       return SRC_RDY;
            1:       return SRC_NEAR;
            default: return SRC_LOAD;
        endcase
    endfunction
endpackage

// File: rtl/iq_cls_fifo.sv
module iq_cls_fifo #(
    parameter int DEPTH  = 32,
    parameter int LOOK   = 3,
    parameter int DISP_W = 1,
    parameter int EW     = 16,
    parameter int TK_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enq_valid,
    input  logic [EW-1:0]   enq_entry,
    input  logic [TK_W-1:0] pop_cnt,
    output logic [EW-1:0]   head_entry [LOOK],
    output logic [LOOK-1:0] head_vld,
    output logic            full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PTR_W-1:0]         rd;
        logic [PTR_W-1:0]         wr;
        logic [CNT_W-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int inc);
        int t;
        t = int'(p) + inc;
        if (t >= DEPTH) t = t - DEPTH;
        return PTR_W'(t);
    endfunction

    always_comb begin
        logic accept;
        int   n;
        st_d   = st_q;
        accept = enq_valid && (int'(st_q.cnt) < DEPTH);
        if (accept) begin
            st_d.mem[st_q.wr] = enq_entry;
            st_d.wr           = ptr_add(st_q.wr, 1);
        end
        st_d.rd = ptr_add(st_q.rd, int'(pop_cnt));
        n = int'(st_q.cnt) + (accept ? 1 : 0) - int'(pop_cnt);
        st_d.cnt = CNT_W'(n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < LOOK; i++) begin
            head_entry[i] = st_q.mem[ptr_add(st_q.rd, i)];
            head_vld[i]   = int'(st_q.cnt) > i;
        end
        full = (DEPTH - int'(st_q.cnt)) < DISP_W;
    end
endmodule

// File: rtl/iq_ready_run.sv
module iq_ready_run #(
    parameter int LOOK          = 3,
    parameter int EW            = 16,
    parameter int TW            = 6,
    parameter int NREG          = 64,
    parameter int TK_W          = 3,
    parameter bit CHECK_OPERAND = 1'b1
) (
    input  logic [EW-1:0]   head_entry [LOOK],
    input  logic [LOOK-1:0] head_vld,
    input  logic [NREG-1:0] reg_ready,
    input  logic [TK_W-1:0] cap,
    output logic [TK_W-1:0] take
);
    logic [LOOK-1:0] op_ok;

    generate
        for (genvar i = 0; i < LOOK; i++) begin : g_op
            if (CHECK_OPERAND) begin : g_chk
                assign op_ok[i] = reg_ready[head_entry[i][TW-1:0]];
            end else begin : g_free
                assign op_ok[i] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        int  t;
        logic go;
        t  = 0;
        go = 1'b1;
        for (int i = 0; i < LOOK; i++) begin
            if (go && head_vld[i] && op_ok[i] && (i < int'(cap))) begin
                t = t + 1;
            end else begin
                go = 1'b0;
            end
        end
        take = TK_W'(t);
    end
endmodule

// File: rtl/multi_fifo_issue.sv
module multi_fifo_issue
    import iq_sel_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int LOOK   = 3,
    parameter int TOTAL  = 4,
    parameter int DISP_W = 1,
    parameter int PW     = 16,
    parameter int TW     = 6,
    parameter int NREG   = 2 ** TW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             enq_valid,
    input  logic [3*PW-1:0]        enq_data,
    input  logic [3*TW-1:0]        enq_tag,
    input  logic [NREG-1:0]        reg_ready,
    input  logic                   oq_req,
    input  logic [PW-1:0]          oq_data,
    output logic                   oq_grant,
    output logic [TOTAL-1:0]       iss_valid,
    output logic [TOTAL*PW-1:0]    iss_data,
    output logic [2*TOTAL-1:0]     iss_src,
    output logic [2:0]             fifo_full
);
    localparam int EW   = PW + TW;
    localparam int TK_W = $clog2(TOTAL + 1);

    logic [EW-1:0]   head_e [NCLS][LOOK];
    logic [LOOK-1:0] head_v [NCLS];
    logic [TK_W-1:0] cap    [NCLS];
    logic [TK_W-1:0] take   [NCLS];

    assign cap[0] = TK_W'(TOTAL);

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            iq_cls_fifo #(
                .DEPTH(DEPTH), .LOOK(LOOK), .DISP_W(DISP_W), .EW(EW), .TK_W(TK_W)
            ) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .enq_valid (enq_valid[c]),
                .enq_entry ({enq_data[c*PW +: PW], enq_tag[c*TW +: TW]}),
                .pop_cnt   (take[c]),
                .head_entry(head_e[c]),
                .head_vld  (head_v[c]),
                .full      (fifo_full[c])
            );

            iq_ready_run #(
                .LOOK(LOOK), .EW(EW), .TW(TW), .NREG(NREG), .TK_W(TK_W),
                .CHECK_OPERAND(c != 0)
            ) u_run (
                .head_entry(head_e[c]),
                .head_vld  (head_v[c]),
                .reg_ready (reg_ready),
                .cap       (cap[c]),
                .take      (take[c])
            );

            if (c < NCLS - 1) begin : g_cap
                assign cap[c+1] = cap[c] - take[c];
            end
        end
    endgenerate

    always_comb begin
        int u0, u1, u2, used;
        u0   = int'(take[0]);
        u1   = int'(take[1]);
        u2   = int'(take[2]);
        used = u0 + u1 + u2;
        oq_grant  = oq_req && (used < TOTAL);
        iss_valid = '0;
        iss_data  = '0;
        iss_src   = '0;
        for (int s = 0; s < TOTAL; s++) begin
            if (s < u0) begin
                iss_valid[s]          = 1'b1;
                iss_data[s*PW +: PW]  = head_e[0][s][EW-1:TW];
                iss_src[2*s +: 2]     = SRC_RDY;
            end else if (s < u0 + u1) begin
                iss_valid[s]          = 1'b1;
                iss_data[s*PW +: PW]  = head_e[1][s-u0][EW-1:TW];
                iss_src[2*s +: 2]     = SRC_NEAR;
            end else if (s < used) begin
                iss_valid[s]          = 1'b1;
                iss_data[s*PW +: PW]  = head_e[2][s-u0-u1][EW-1:TW];
                iss_src[2*s +: 2]     = SRC_LOAD;
            end else if ((s == used) && oq_grant) begin
                iss_valid[s]          = 1'b1;
                iss_data[s*PW +: PW]  = oq_data;
                iss_src[2*s +: 2]     = SRC_OOO;
            end
        end
    end
endmodule

// File: rtl/multi_fifo_issue_chk.sv
module multi_fifo_issue_chk #(
    parameter int TOTAL = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         enq_valid,
    input logic               oq_req,
    input logic               oq_grant,
    input logic [TOTAL-1:0]   iss_valid,
    input logic [2*TOTAL-1:0] iss_src,
    input logic [2:0]         fifo_full
);
    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_valid == '0) && (fifo_full == 3'b000));

    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        oq_grant |-> oq_req);

    // R10
    slots_packed_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & (iss_valid + 1'b1)) == '0);

    // R5
    slot_order_01_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> iss_src[3:2] >= iss_src[1:0]);

    // R5
    slot_order_12_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid[2] |-> iss_src[5:4] >= iss_src[3:2]);

    // R7
    full_moves_with_traffic_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fifo_full) |-> $past((|enq_valid) || (|iss_valid)));
endmodule

bind multi_fifo_issue multi_fifo_issue_chk #(.TOTAL(TOTAL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enq_valid(enq_valid),
    .oq_req   (oq_req),
    .oq_grant (oq_grant),
    .iss_valid(iss_valid),
    .iss_src  (iss_src),
    .fifo_full(fifo_full)
);

// File: tb/multi_fifo_issue_bench.sv
module multi_fifo_issue_bench;
    localparam int CLK_P  = 10;
    localparam int DEPTH  = 8;
    localparam int LOOK   = 3;
    localparam int TOTAL  = 4;
    localparam int DISP_W = 2;
    localparam int PW     = 8;
    localparam int TW     = 4;
    localparam int NREG   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]          enq_valid = '0;
    logic [3*PW-1:0]     enq_data  = '0;
    logic [3*TW-1:0]     enq_tag   = '0;
    logic [NREG-1:0]     reg_ready = '0;
    logic                oq_req    = 1'b0;
    logic [PW-1:0]       oq_data   = '0;
    logic                oq_grant;
    logic [TOTAL-1:0]    iss_valid;
    logic [TOTAL*PW-1:0] iss_data;
    logic [2*TOTAL-1:0]  iss_src;
    logic [2:0]          fifo_full;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int seq    = 0;

    int qp [3][DEPTH];
    int qt [3][DEPTH];
    int qn [3];

    always #(CLK_P/2) clk = ~clk;

    multi_fifo_issue #(
        .DEPTH(DEPTH), .LOOK(LOOK), .TOTAL(TOTAL), .DISP_W(DISP_W),
        .PW(PW), .TW(TW), .NREG(NREG)
    ) u_multi_fifo_issue (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data),
        .enq_tag(enq_tag), .reg_ready(reg_ready), .oq_req(oq_req), .oq_data(oq_data),
        .oq_grant(oq_grant), .iss_valid(iss_valid), .iss_data(iss_data),
        .iss_src(iss_src), .fifo_full(fifo_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit entry_ready(input int c, input int i);
        if (c == 0) return 1'b1;
        return reg_ready[qt[c][i]];
    endfunction

    // Compare outputs with the bench model, then advance the model by one edge.
    task automatic check_and_step();
        int ev [TOTAL];
        int ed [TOTAL];
        int es [TOTAL];
        int tk [3];
        int used;
        bit eg;
        used = 0;
        for (int s = 0; s < TOTAL; s++) begin ev[s] = 0; ed[s] = 0; es[s] = 0; end
        for (int c = 0; c < 3; c++) begin
            tk[c] = 0;
            for (int i = 0; i < LOOK; i++) begin
                if (i < qn[c] && entry_ready(c, i) && used < TOTAL && tk[c] == i) begin
                    ev[used] = 1; ed[used] = qp[c][i]; es[used] = c;
                    tk[c]++; used++;
                end
            end
        end
        eg = oq_req && (used < TOTAL);
        if (eg) begin ev[used] = 1; ed[used] = int'(oq_data); es[used] = 3; end
        chk(oq_grant == eg, "R6 grant", int'(oq_grant), int'(eg));
        for (int s = 0; s < TOTAL; s++) begin
            chk(iss_valid[s] == ev[s][0], "R10/R6/R4 slot valid", int'(iss_valid[s]), ev[s]);
            if (ev[s] != 0 && iss_valid[s]) begin
                chk(int'(iss_src[2*s +: 2]) == es[s], "R5 slot source",
                    int'(iss_src[2*s +: 2]), es[s]);
                chk(int'(iss_data[s*PW +: PW]) == ed[s], "R2/R3/R4/R9 slot data",
                    int'(iss_data[s*PW +: PW]), ed[s]);
            end
        end
        for (int c = 0; c < 3; c++) begin
            bit ef;
            ef = (DEPTH - qn[c]) < DISP_W;
            chk(fifo_full[c] == ef, "R7 full flag", int'(fifo_full[c]), int'(ef));
        end
        for (int c = 0; c < 3; c++) begin
            int pre;
            pre = qn[c];
            for (int i = 0; i + tk[c] < DEPTH; i++) begin
                qp[c][i] = qp[c][i + tk[c]];
                qt[c][i] = qt[c][i + tk[c]];
            end
            qn[c] = qn[c] - tk[c];
            if (enq_valid[c] && pre < DEPTH) begin   // R8 drop at capacity
                qp[c][qn[c]] = int'(enq_data[c*PW +: PW]);
                qt[c][qn[c]] = int'(enq_tag[c*TW +: TW]);
                qn[c]++;
            end
        end
    endtask

    task automatic drive_random(input int enq_pct, input int rdy_pct);
        for (int c = 0; c < 3; c++) begin
            enq_valid[c] = ($urandom_range(99) < enq_pct);
            enq_data[c*PW +: PW] = PW'(seq);
            seq++;
            enq_tag[c*TW +: TW] = TW'($urandom_range(NREG - 1));
        end
        for (int r = 0; r < NREG; r++) reg_ready[r] = ($urandom_range(99) < rdy_pct);
        oq_req  = ($urandom_range(99) < 50);
        oq_data = PW'($urandom);
    endtask

    initial begin
        int drained;
        void'($urandom(32'd1234));
        for (int c = 0; c < 3; c++) qn[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: empty after reset
        chk(iss_valid == '0, "R1 no issue", int'(iss_valid), 0);
        chk(fifo_full == '0, "R1 not full", int'(fifo_full), 0);
        chk(oq_grant == 1'b0, "R1 no grant without request", int'(oq_grant), 0);
        check_and_step();

        // R8 directed: overfill the almost-ready queue with its operand held not ready
        for (int k = 0; k < DEPTH + 3; k++) begin
            @(negedge clk);
            enq_valid = 3'b010;
            enq_data[PW +: PW] = PW'(8'h40 + k);
            enq_tag[TW +: TW]  = '0;
            reg_ready = '0;
            oq_req = 1'b1;
            oq_data = PW'(k);
            #1;
            check_and_step();
        end
        // R7: full with DISP_W free margin missing
        chk(fifo_full[1] == 1'b1, "R7 full at capacity", int'(fifo_full[1]), 1);
        drained = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            enq_valid = '0;
            reg_ready = '1;
            oq_req = 1'b0;
            #1;
            for (int s = 0; s < TOTAL; s++) begin
                if (iss_valid[s] && iss_src[2*s +: 2] == 2'd1) begin
                    chk(int'(iss_data[s*PW +: PW]) == 8'h40 + drained, "R8 kept order",
                        int'(iss_data[s*PW +: PW]), 8'h40 + drained);
                    drained++;
                end
            end
            check_and_step();
        end
        chk(drained == DEPTH, "R8 overflow dropped", drained, DEPTH);

        // R4 directed: blocked head of load-tail queue holds younger ready entries
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            enq_valid = 3'b100;
            enq_data[2*PW +: PW] = PW'(8'h80 + k);
            enq_tag[2*TW +: TW]  = TW'(k == 0 ? 5 : 6);
            reg_ready = '0;
            reg_ready[6] = 1'b1;
            #1;
            check_and_step();
        end
        @(negedge clk);
        enq_valid = '0;
        #1;
        chk(iss_valid == '0, "R4 head blocks run", int'(iss_valid), 0);
        check_and_step();
        @(negedge clk);
        reg_ready[5] = 1'b1;
        #1;
        chk(iss_valid == 4'b0111, "R4 run released", int'(iss_valid), 7);
        check_and_step();

        // Random traffic: filling phase then mixed phase
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            drive_random(75, 20);
            #1;
            check_and_step();
        end
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            drive_random(55, 60);
            #1;
            check_and_step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule